// File: doc/BRIEF.md
# Streaming I2C ADC Reader

This block is an I2C bus master that keeps a single-channel I2C analog-to-digital converter streaming. When it is told to start, it signals a start condition and sends one read-address byte. After that it clocks in conversion results for as long as it is allowed to. Each result arrives as a high byte and then a low byte. The master acknowledges every byte, so the converter keeps sending new results without the address being sent again.

Every time a low byte has been taken in and answered, the block presents the assembled 12-bit result with a one-clock valid strobe. That answer is an ACK while streaming, or a NAK on the last result before the stream is closed. A stop request lets the result in flight complete. The master then answers its low byte with a NAK, sends a stop condition, and holds the bus idle for a settling time before it accepts another start.

A divider derives four evenly spaced phase ticks per bus-clock period from the system clock. The data line is updated in the middle of the low half of SCL and sampled in the middle of the high half. The data pin is driven through a tri-state buffer whose enable is also brought out, so the direction of the line can be seen at any time.

Top module: `i2cs_adc_stream`

## Requirements
- R1: While reset is high, and afterwards until a start is requested, SCL is 1, SDA is driven to 1 (drive enable 1), sample_valid is 0 and sample is 0.
- R2: A one-cycle start_req in idle produces a falling SDA edge while SCL is high. It is followed by the address byte {DEV_ADDR, 1} (8'h9B with defaults), sent MSB first, one bit per SCL pulse.
- R3: If SDA is high when the acknowledge bit after the address is sampled, the master returns to idle. No sample is strobed, and SCL and SDA are left high without a stop condition.
- R4: The SDA drive enable is 0 at every SCL rising edge of the address-acknowledge bit and of each data bit, and 1 during master-driven bits.
- R5: A result is formed from bits [3:0] of the high byte, placed above the 8 bits of the low byte (MSB first on the wire). Bits [7:4] of the high byte have no effect on sample.
- R6: While streaming, the master drives SDA low in the acknowledge bit of every high and low byte, and no further start condition or address byte is sent.
- R7: sample_valid is high for exactly one system clock per result. In steady streaming, consecutive strobes are 18 SCL periods apart (16 data bits plus 2 acknowledge bits).
- R8: After a stop_req pulse, the result in flight still completes and is strobed. Its low byte gets a NAK (SDA high in that acknowledge bit), then a stop condition follows, and SCL stays high for WAIT_PER SCL periods. After that a new start_req begins a new session.
- R9: While SCL is high, SDA changes only to form start or stop conditions.
- R10: The SCL period is 4*QTR_CYC system clocks, where QTR_CYC = CLK_HZ/(4*SCL_HZ). SCL stays high in idle and during the settling wait.
- R11: start_req while a session is active, and stop_req while idle, have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to open a streaming session |
| stop_req | input | 1 | One-cycle request to close the session after the current result |
| scl | output | 1 | Bus clock, registered |
| sda | inout | 1 | Bus data line through a tri-state buffer |
| sda_drive_en | output | 1 | 1 while the master drives SDA, 0 while the line is released |
| sample | output | SAMPLE_W | Last assembled conversion result |
| sample_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A behavioural converter model streams a table of high/low byte pairs. Some high bytes carry a non-zero top nibble, and the table includes all-zero, all-one and single-bit values, so a result built from the wrong nibble or the wrong bit order differs from its expected value. A session whose address is not acknowledged is separated from a normal one by the strobe count and the idle bus levels. A stop request placed right after a strobe shows whether the in-flight result completes and gets a NAK. Stray start requests during streaming and stop requests in idle must leave the counts of start and stop conditions and of acknowledges unchanged.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RD_HI,
    ST_ACK_HI,
    ST_RD_LO,
    ST_ACK_LO,
    ST_NAK,
    ST_STOP,
    ST_WAIT
  } bus_state_t;

  // quarter phases of one SCL period
  localparam logic [1:0] PH_FALL = 2'd0;  // SCL goes low
  localparam logic [1:0] PH_SET  = 2'd1;  // SDA updated, mid-low
  localparam logic [1:0] PH_RISE = 2'd2;  // SCL goes high
  localparam logic [1:0] PH_SAMP = 2'd3;  // SDA sampled, mid-high

endpackage

// File: rtl/i2cs_quarter_tick.sv
`timescale 1ns/1ps
module i2cs_quarter_tick #(
  parameter int QTR_CYC = 62
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase
);
  localparam int CNT_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       ph_q;

  assign tick  = run && (cnt_q == CNT_LAST);
  assign phase = ph_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      ph_q  <= 2'd0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      ph_q  <= ph_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: phases advance by one per tick while running
  a_r10_phase_order: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(tick)) |-> (phase == $past(phase) + 2'd1));

endmodule

// File: rtl/i2cs_in_sync.sv
`timescale 1ns/1ps
module i2cs_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2cs_rx_assemble.sv
`timescale 1ns/1ps
module i2cs_rx_assemble #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  input  logic                hi_latch,
  input  logic                emit,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_valid
);
  localparam int BYTE_W = 8;
  localparam int HI_W   = SAMPLE_W - BYTE_W;

  logic [BYTE_W-1:0] shreg_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q      <= '0;
      hi_q         <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= emit;
      if (shift_en) shreg_q <= {shreg_q[BYTE_W-2:0], bit_in};
      // only the low bits of the high byte carry the result
      if (hi_latch) hi_q <= shreg_q[HI_W-1:0];
      if (emit)     sample <= {hi_q, shreg_q};
    end
  end

  // R5: the result only changes when a strobe is produced
  a_r5_sample_hold: assert property (@(posedge clk) disable iff (rst)
    !emit |=> $stable(sample));

endmodule

// File: rtl/i2cs_adc_stream.sv
`timescale 1ns/1ps
module i2cs_adc_stream
  import i2cs_pkg::*;
#(
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          SCL_HZ      = 200_000,
  parameter int          SAMPLE_W    = 12,
  parameter int          WAIT_PER    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'b1001101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic                stop_req,
  output logic                scl,
  inout  wire                 sda,
  output logic                sda_drive_en,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_valid
);
  localparam int          QTR_CYC     = CLK_HZ / (4 * SCL_HZ);
  localparam logic [7:0]  ADDR_BYTE   = {DEV_ADDR, 1'b1};
  localparam int          WAIT_W      = (WAIT_PER > 1) ? $clog2(WAIT_PER) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_PER - 1);
  localparam int          SAMPLE_CLKS = 18 * 4 * QTR_CYC;
  localparam int          GAP_W       = $clog2(SAMPLE_CLKS) + 1;

  bus_state_t        state;
  logic              tick;
  logic [1:0]        phase;
  logic              sda_in;
  logic              scl_q;
  logic              oe_q;
  logic              out_q;
  logic [2:0]        bcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              stop_pend;
  logic              samp_tick;
  logic              rx_shift;
  logic              rx_hi;
  logic              rx_emit;

  // tri-state pad
  assign sda          = oe_q ? out_q : 1'bz;
  assign scl          = scl_q;
  assign sda_drive_en = oe_q;

  i2cs_quarter_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (state != ST_IDLE),
    .tick  (tick),
    .phase (phase)
  );

  i2cs_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sda),
    .dout (sda_in)
  );

  assign samp_tick = tick && (phase == PH_SAMP);
  assign rx_shift  = samp_tick && ((state == ST_RD_HI) || (state == ST_RD_LO));
  assign rx_hi     = samp_tick && (state == ST_ACK_HI);
  assign rx_emit   = samp_tick && ((state == ST_ACK_LO) || (state == ST_NAK));

  i2cs_rx_assemble #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (rx_shift),
    .bit_in       (sda_in),
    .hi_latch     (rx_hi),
    .emit         (rx_emit),
    .sample       (sample),
    .sample_valid (sample_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      scl_q     <= 1'b1;
      oe_q      <= 1'b1;
      out_q     <= 1'b1;
      bcnt      <= '0;
      wcnt      <= '0;
      stop_pend <= 1'b0;
    end else begin
      if ((state != ST_IDLE) && stop_req) stop_pend <= 1'b1;
      if (state == ST_IDLE) begin
        scl_q     <= 1'b1;
        oe_q      <= 1'b1;
        out_q     <= 1'b1;
        bcnt      <= '0;
        wcnt      <= '0;
        stop_pend <= 1'b0;
        if (start_req) state <= ST_START;
      end else if (tick) begin
        unique case (phase)
          PH_FALL: begin
            if ((state != ST_START) && (state != ST_WAIT)) scl_q <= 1'b0;
          end
          PH_SET: begin
            unique case (state)
              ST_START:  begin oe_q <= 1'b1; out_q <= 1'b0; end
              ST_ADDR:   begin oe_q <= 1'b1; out_q <= ADDR_BYTE[3'd7 - bcnt]; end
              ST_ADDR_ACK, ST_RD_HI, ST_RD_LO: oe_q <= 1'b0;
              ST_ACK_HI, ST_ACK_LO, ST_STOP: begin oe_q <= 1'b1; out_q <= 1'b0; end
              ST_NAK:    begin oe_q <= 1'b1; out_q <= 1'b1; end
              default: ;
            endcase
          end
          PH_RISE: begin
            if ((state != ST_START) && (state != ST_WAIT)) scl_q <= 1'b1;
          end
          default: begin  // PH_SAMP
            unique case (state)
              ST_START: begin
                state <= ST_ADDR;
                bcnt  <= '0;
              end
              ST_ADDR: begin
                if (bcnt == 3'd7) state <= ST_ADDR_ACK;
                bcnt <= bcnt + 3'd1;
              end
              ST_ADDR_ACK: begin
                if (!sda_in) begin
                  state <= ST_RD_HI;
                end else begin
                  state <= ST_IDLE;
                  oe_q  <= 1'b1;
                  out_q <= 1'b1;
                end
                bcnt <= '0;
              end
              ST_RD_HI: begin
                if (bcnt == 3'd7) state <= ST_ACK_HI;
                bcnt <= bcnt + 3'd1;
              end
              ST_ACK_HI: state <= ST_RD_LO;
              ST_RD_LO: begin
                if (bcnt == 3'd7) state <= (stop_pend || stop_req) ? ST_NAK : ST_ACK_LO;
                bcnt <= bcnt + 3'd1;
              end
              ST_ACK_LO: state <= ST_RD_HI;
              ST_NAK:    state <= ST_STOP;
              ST_STOP: begin
                out_q <= 1'b1;   // rising SDA with SCL high
                wcnt  <= '0;
                state <= ST_WAIT;
              end
              ST_WAIT: begin
                if (wcnt == WAIT_LAST) state <= ST_IDLE;
                else                   wcnt  <= wcnt + 1'b1;
              end
              default: state <= ST_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  logic             line_lvl;
  logic [GAP_W-1:0] gap_cnt;
  logic             gap_seen;

  assign line_lvl = !oe_q || out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      gap_seen <= 1'b0;
    end else begin
      if (sample_valid) begin
        gap_cnt  <= '0;
        gap_seen <= 1'b1;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (state == ST_IDLE) gap_seen <= 1'b0;
    end
  end

  // R9: data line steady while SCL high, except start and stop phases
  a_r9_sda_stable: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && ($past(state) != ST_START) && ($past(state) != ST_STOP))
      |-> $stable(line_lvl));

  // R4: line released only in slave-driven bits and the handover into the next bit
  a_r4_release_window: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> !(state inside {ST_IDLE, ST_START, ST_ADDR, ST_STOP, ST_WAIT}));

  // R10: SCL parked high while idle or settling
  a_r10_scl_parked: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) || (state == ST_WAIT)) |-> scl_q);

  // R7: strobe lasts one clock
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R7: steady-state strobe spacing of 18 SCL periods
  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && gap_seen) |-> (gap_cnt == GAP_W'(SAMPLE_CLKS - 1)));

endmodule

// File: tb/tb_i2cs_adc_stream.sv
`timescale 1ns/1ps
module tb_i2cs_adc_stream;
  localparam int CLK_HZ      = 1_600_000;
  localparam int SCL_HZ      = 100_000;
  localparam int QTR         = CLK_HZ / (4 * SCL_HZ);
  localparam int SCL_CLKS    = 4 * QTR;
  localparam int SAMPLE_CLKS = 18 * SCL_CLKS;
  localparam int WAIT_PER    = 2;

  // high/low byte pairs streamed by the converter model; expected result = [11:0]
  localparam logic [15:0] VEC [8] = '{
    16'h0ABC, 16'hF123, 16'h0FFF, 16'h0000,
    16'h5800, 16'h0001, 16'hA7E5, 16'h0555
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic stop_req = 1'b0;
  logic scl;
  wire  sda;
  logic drive_en;
  logic [11:0] sample;
  logic valid;
  logic slv_low = 1'b0;

  pullup (sda);
  assign sda = slv_low ? 1'b0 : 1'bz;

  always #2.5 clk = ~clk;

  i2cs_adc_stream #(
    .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .SAMPLE_W(12), .WAIT_PER(WAIT_PER),
    .SYNC_STAGES(2), .DEV_ADDR(7'b1001101)
  ) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .scl(scl), .sda(sda), .sda_drive_en(drive_en),
    .sample(sample), .sample_valid(valid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int n_start = 0, n_stop = 0, n_mack = 0, n_mnak = 0, oe_bad = 0, slv_idx = 0;
  logic [7:0] last_addr = 8'h00;
  bit ack_ok = 1'b0;

  always @(negedge sda) if (scl === 1'b1) n_start++;
  always @(posedge sda) if (scl === 1'b1) n_stop++;

  initial begin
    logic [7:0] addr;
    logic [7:0] byt;
    logic [15:0] w;
    logic mk;
    bit going;
    forever begin
      @(negedge sda);
      if (scl !== 1'b1) continue;
      addr = 8'h00;
      for (int i = 0; i < 8; i++) begin
        @(posedge scl);
        addr = {addr[6:0], sda};
      end
      last_addr = addr;
      @(negedge scl);
      slv_low = ack_ok;
      @(posedge scl);
      if (drive_en) oe_bad++;
      if (!ack_ok) continue;
      @(negedge scl);
      going = 1'b1;
      while (going) begin
        w = VEC[slv_idx];
        for (int b = 0; b < 2; b++) begin
          byt = (b == 0) ? w[15:8] : w[7:0];
          for (int i = 7; i >= 0; i--) begin
            slv_low = !byt[i];
            @(posedge scl);
            if (drive_en) oe_bad++;
            @(negedge scl);
          end
          slv_low = 1'b0;
          @(posedge scl);
          mk = sda;
          @(negedge scl);
          if (mk) begin
            n_mnak++;
            going = 1'b0;
            break;
          end else begin
            n_mack++;
          end
        end
        slv_idx = (slv_idx + 1) % 8;
      end
    end
  end

  // ---------------- output monitor ----------------
  longint cyc = 0;
  longint last_v = 0;
  int n_valid = 0, mon_idx = 0;
  bit have_prev = 1'b0;
  bit prev_valid = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (valid) begin
      chk(!prev_valid, "R7", "strobe longer than one cycle", 2, 1);
      chk(sample == VEC[mon_idx][11:0], "R5", "sample value",
          sample, VEC[mon_idx][11:0]);
      if (have_prev)
        chk((cyc - last_v) == SAMPLE_CLKS, "R7", "strobe spacing",
            cyc - last_v, SAMPLE_CLKS);
      have_prev = 1'b1;
      last_v = cyc;
      n_valid++;
      mon_idx = (mon_idx + 1) % 8;
    end
    prev_valid = valid;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(posedge clk); #1 stop_req = 1'b1;
    @(posedge clk); #1 stop_req = 1'b0;
  endtask

  task automatic wait_valids(input int n);
    while (n_valid < n) @(negedge clk);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    longint t0, t1;
    bit scl_dropped;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(scl == 1'b1, "R1", "scl after reset", scl, 1);
    chk(sda == 1'b1, "R1", "sda after reset", sda, 1);
    chk(drive_en == 1'b1, "R1", "drive enable after reset", drive_en, 1);
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
    chk(sample == 12'h000, "R1", "sample after reset", sample, 0);
    #1 rst = 1'b0;

    // R11: stop request while idle does nothing
    pulse_stop();
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk(scl == 1'b1 && sda == 1'b1, "R11", "bus idle after stop in idle", {scl, sda}, 3);
    chk(n_start == 0, "R11", "no start from stop in idle", n_start, 0);

    // R2 / R3: address not acknowledged
    ack_ok = 1'b0;
    pulse_start();
    repeat (12 * SCL_CLKS) @(posedge clk);
    @(negedge clk);
    chk(n_start == 1, "R2", "start condition seen", n_start, 1);
    chk(last_addr == 8'h9B, "R2", "address byte", last_addr, 8'h9B);
    chk(n_valid == 0, "R3", "no strobe after address NAK", n_valid, 0);
    chk(scl == 1'b1 && sda == 1'b1, "R3", "bus high after address NAK", {scl, sda}, 3);
    chk(n_stop == 0, "R3", "no stop condition after address NAK", n_stop, 0);

    // streaming session
    ack_ok = 1'b1;
    have_prev = 1'b0;
    pulse_start();
    wait_valids(3);
    @(posedge scl); t0 = cyc;
    @(posedge scl); t1 = cyc;
    chk((t1 - t0) == SCL_CLKS, "R10", "SCL period", t1 - t0, SCL_CLKS);
    pulse_start();   // R11: ignored while busy
    wait_valids(10);
    repeat (2 * SCL_CLKS) @(negedge clk);
    chk(n_start == 2, "R6", "no re-addressing while streaming (R11 start ignored)", n_start, 2);
    chk(n_mack == 20, "R6", "master ACK count", n_mack, 20);

    // R8: stop right after a strobe
    pulse_stop();
    t0 = cyc;
    while (n_stop < 1 && (cyc - t0) < 40 * SCL_CLKS) @(negedge clk);
    chk(n_stop == 1, "R8", "stop condition seen", n_stop, 1);
    chk(n_valid == 11, "R8", "in-flight result strobed", n_valid, 11);
    chk(n_mnak == 1, "R8", "NAK on last low byte", n_mnak, 1);
    chk(n_mack == 21, "R8", "high byte of last result acknowledged", n_mack, 21);
    scl_dropped = 1'b0;
    for (int i = 0; i < WAIT_PER * SCL_CLKS - 2; i++) begin
      @(negedge clk);
      if (scl != 1'b1) scl_dropped = 1'b1;
    end
    chk(!scl_dropped, "R10", "SCL high during settling wait", scl_dropped, 0);
    repeat (2 * SCL_CLKS) @(posedge clk);

    // R8: new session after the wait
    have_prev = 1'b0;
    pulse_start();
    wait_valids(13);
    chk(n_start == 3, "R8", "restart accepted", n_start, 3);
    pulse_stop();
    t0 = cyc;
    while (n_stop < 2 && (cyc - t0) < 40 * SCL_CLKS) @(negedge clk);
    repeat (SCL_CLKS) @(negedge clk);
    chk(n_valid == 14, "R8", "second session strobes", n_valid, 14);
    chk(oe_bad == 0, "R4", "drive enable high while slave drives", oe_bad, 0);
    chk(n_start == 3 && n_stop == 2, "R9", "SDA edges under SCL high",
        n_start * 10 + n_stop, 32);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule